// File: doc/BRIEF.md
# Frequency sweep step sequencer

This block sequences a linear frequency sweep for a waveform synthesiser. It holds no configuration of its own. The start word, the delta word, the increment count and the three mode selects arrive as static inputs. A rising edge on an asynchronous control pin starts the sweep. From that edge the block presents the current frequency word, and it adds the delta once per step until the programmed number of increments has been taken. The next step event after that sets a done flag and freezes the final word until another start edge arrives.

A separate timer paces the steps and shapes the bursts. It supplies an interval-done pulse and a burst-active level. The sequencer gives it a one-cycle kick whenever a new frequency word appears, so that the timer can restart its interval. Steps come either from the timer or from later edges on the control pin. An output-enable signal tells the synthesiser when to emit the frequency and when to hold midscale. In continuous mode the enable stays high. In burst mode the enable follows the timer's burst window or the synchronised control pin.

Top module: `sweep_seq`

## Requirements
- R1: While and after reset, before any start edge, freqWord is 0 and outEnable, sweepDone and intervalKick are all 0.
- R2: ctrlPin passes through two synchronising flops before edge detection. A start edge takes effect on the second rising clock edge after the first clock edge that samples ctrlPin high.
- R3: A start edge while idle or done loads startFreq into freqWord and clears sweepDone. intervalKick is high for exactly the one cycle in which a newly loaded or stepped word is first presented.
- R4: Each step adds deltaWord to freqWord modulo 2^FREQ_W. After incCount steps, the next step event sets sweepDone and holds freqWord, and no further kick occurs until a new start edge.
- R5: With extIncr = 0, a step event is an intervalDone pulse while the sweep runs. Control-pin edges during a running sweep have no effect.
- R6: With extIncr = 1, each synchronised rising edge after the start edge is a step event, and intervalDone has no effect.
- R7: With contMode = 1, outEnable is 1 whenever a sweep is running or done.
- R8: With contMode = 0 and extBurst = 0, outEnable equals burstActive while running or done.
- R9: With contMode = 0 and extBurst = 1, outEnable equals the synchronised control pin level while running or done.
- R10: Before the first start edge, outEnable is 0 regardless of the mode selects and the timer inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlPin | input | 1 | Raw asynchronous control pin |
| startFreq | input | FREQ_W | Start frequency word |
| deltaWord | input | FREQ_W | Step added per increment |
| incCount | input | CNT_W | Number of increments per sweep |
| contMode | input | 1 | 1: continuous output, 0: burst gating |
| extBurst | input | 1 | 1: burst window taken from the control pin |
| extIncr | input | 1 | 1: steps taken from control-pin edges |
| intervalDone | input | 1 | Timer pulse marking the end of an interval |
| burstActive | input | 1 | Timer level marking the burst window |
| freqWord | output | FREQ_W | Current frequency word |
| outEnable | output | 1 | 1: emit frequency, 0: force midscale |
| sweepDone | output | 1 | Sweep finished, final word held |
| intervalKick | output | 1 | One-cycle pulse on each new word |

## Verification
A wrong step counter shows up at the sweep's end. sweepDone rises one step early or late, and the held freqWord differs from start plus incCount times delta, so the error is visible on the cycle of the final step event. A wrong state register shows sooner. A pin edge during an automatic sweep would reload startFreq, or a missed start would leave the outputs at zero. Either shows up at the ports two edges after the synchroniser sees the pin. Gate selection faults appear on outEnable in the same cycle as the timer or the pin level changes.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  // strobes from the control path to the datapath
  typedef struct packed {
    logic load;  // take the start word
    logic step;  // add the delta word
  } stepCtl_t;
endpackage

// File: rtl/sweep_sync.sv
module sweep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  output logic pinLevel,
  output logic pinRise
);
  logic [STAGES-1:0] chain;
  logic prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '0;
      prevLevel <= 1'b0;
    end else begin
      chain     <= {chain[STAGES-2:0], pinRaw};
      prevLevel <= chain[STAGES-1];
    end
  end

  assign pinLevel = chain[STAGES-1];
  assign pinRise  = chain[STAGES-1] & ~prevLevel;
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinLevel,
  input  logic             pinRise,
  input  logic [CNT_W-1:0] incCount,
  input  logic             contMode,
  input  logic             extBurst,
  input  logic             extIncr,
  input  logic             intervalDone,
  input  logic             burstActive,
  output stepCtl_t         ctl,
  output logic             active,
  output logic             outEnable,
  output logic             sweepDone,
  output logic             intervalKick
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} sweepState_t;

  sweepState_t      state;
  logic [CNT_W-1:0] stepsLeft;
  logic             stepEvt;
  logic             finish;
  logic             gateSel;

  always_comb begin
    stepEvt  = (state == S_RUN) && (extIncr ? pinRise : intervalDone);
    ctl.load = pinRise && (state != S_RUN);
    ctl.step = stepEvt && (stepsLeft != '0);
    finish   = stepEvt && (stepsLeft == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_IDLE;
      stepsLeft    <= '0;
      intervalKick <= 1'b0;
    end else begin
      intervalKick <= ctl.load | ctl.step;
      if (ctl.load) begin
        state     <= S_RUN;
        stepsLeft <= incCount;
      end else if (ctl.step) begin
        stepsLeft <= stepsLeft - 1'b1;
      end else if (finish) begin
        state <= S_DONE;
      end
    end
  end

  always_comb begin
    if (contMode)      gateSel = 1'b1;
    else if (extBurst) gateSel = pinLevel;
    else               gateSel = burstActive;
  end

  assign active    = (state != S_IDLE);
  assign outEnable = active & gateSel;
  assign sweepDone = (state == S_DONE);
endmodule

// File: rtl/sweep_dpath.sv
module sweep_dpath
  import sweep_pkg::*;
#(
  parameter int FREQ_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic [FREQ_W-1:0] startFreq,
  input  logic [FREQ_W-1:0] deltaWord,
  output logic [FREQ_W-1:0] freqWord
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         freqWord <= '0;
    else if (ctl.load) freqWord <= startFreq;
    else if (ctl.step) freqWord <= freqWord + deltaWord;
  end
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int CNT_W  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlPin,
  input  logic [FREQ_W-1:0] startFreq,
  input  logic [FREQ_W-1:0] deltaWord,
  input  logic [CNT_W-1:0]  incCount,
  input  logic              contMode,
  input  logic              extBurst,
  input  logic              extIncr,
  input  logic              intervalDone,
  input  logic              burstActive,
  output logic [FREQ_W-1:0] freqWord,
  output logic              outEnable,
  output logic              sweepDone,
  output logic              intervalKick
);
  stepCtl_t ctl;
  logic     active;
  logic     pinLevel;
  logic     pinRise;

  sweep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .pinRaw(ctrlPin),
    .pinLevel(pinLevel), .pinRise(pinRise)
  );

  sweep_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pinRise(pinRise),
    .incCount(incCount), .contMode(contMode), .extBurst(extBurst),
    .extIncr(extIncr), .intervalDone(intervalDone), .burstActive(burstActive),
    .ctl(ctl), .active(active), .outEnable(outEnable),
    .sweepDone(sweepDone), .intervalKick(intervalKick)
  );

  sweep_dpath #(.FREQ_W(FREQ_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startFreq(startFreq),
    .deltaWord(deltaWord), .freqWord(freqWord)
  );
endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk
  import sweep_pkg::*;
#(
  parameter int FREQ_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input stepCtl_t          ctl,
  input logic              active,
  input logic              contMode,
  input logic [FREQ_W-1:0] startFreq,
  input logic [FREQ_W-1:0] deltaWord,
  input logic [FREQ_W-1:0] freqWord,
  input logic              outEnable,
  input logic              sweepDone,
  input logic              intervalKick
);
  a_r3_load_start: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (freqWord == $past(startFreq)));

  a_r4_step_adds: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (freqWord == $past(freqWord + deltaWord)));

  a_r4_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (sweepDone && !ctl.load) |=> $stable(freqWord));

  a_r4_no_kick_done: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> !intervalKick);

  a_r3_kick_single: assert property (@(posedge clk) disable iff (!rstN)
    (intervalKick && !ctl.load && !ctl.step) |=> !intervalKick);

  a_r7_cont_enable: assert property (@(posedge clk) disable iff (!rstN)
    (contMode && active) |-> outEnable);

  a_r10_idle_off: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!outEnable && !sweepDone));
endmodule

bind sweep_seq sweep_seq_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .active(active), .contMode(contMode),
  .startFreq(startFreq), .deltaWord(deltaWord), .freqWord(freqWord),
  .outEnable(outEnable), .sweepDone(sweepDone), .intervalKick(intervalKick)
);

// File: tb/tb_sweep_seq.sv
`timescale 1ns/1ps
module tb_sweep_seq;
  localparam int FW = 24;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlPin = 1'b0;
  logic [FW-1:0] startFreq = '0;
  logic [FW-1:0] deltaWord = '0;
  logic [CW-1:0] incCount = '0;
  logic contMode = 1'b1, extBurst = 1'b0, extIncr = 1'b0;
  logic intervalDone = 1'b0, burstActive = 1'b0;
  logic [FW-1:0] freqWord;
  logic outEnable, sweepDone, intervalKick;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int tick = 0;

  sweep_seq #(.FREQ_W(FW), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .ctrlPin(ctrlPin), .startFreq(startFreq),
    .deltaWord(deltaWord), .incCount(incCount), .contMode(contMode),
    .extBurst(extBurst), .extIncr(extIncr), .intervalDone(intervalDone),
    .burstActive(burstActive), .freqWord(freqWord), .outEnable(outEnable),
    .sweepDone(sweepDone), .intervalKick(intervalKick)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: pin history, sweep phase, remaining steps
  logic [FW-1:0] mFreq = '0;
  int  mLeft = 0;
  int  mPhase = 0;  // 0 idle, 1 running, 2 finished
  bit  mKick = 0;
  bit  mS1 = 0, mS2 = 0, mPrev = 0;
  bit  modelOn = 0;

  function automatic bit expEnable();
    if (mPhase == 0) return 1'b0;
    if (contMode) return 1'b1;
    if (extBurst) return mS2;
    return burstActive;
  endfunction

  always @(posedge clk) begin
    bit rise, stepE;
    cyc++;
    if (!rstN) begin
      mFreq = '0; mLeft = 0; mPhase = 0; mKick = 0;
      mS1 = 0; mS2 = 0; mPrev = 0;
    end else begin
      rise  = mS2 && !mPrev;
      stepE = (mPhase == 1) && (extIncr ? rise : intervalDone);
      mKick = 0;
      if (rise && mPhase != 1) begin
        mFreq = startFreq; mLeft = int'(incCount); mPhase = 1; mKick = 1;
      end else if (stepE) begin
        if (mLeft == 0) mPhase = 2;
        else begin mFreq = mFreq + deltaWord; mLeft--; mKick = 1; end
      end
      mPrev = mS2; mS2 = mS1; mS1 = ctrlPin;
    end
    #2;
    if (modelOn) begin
      check(freqWord == mFreq, extIncr ? "R6 freqWord" : "R5 freqWord", freqWord, mFreq);
      check(sweepDone == (mPhase == 2), "R4 sweepDone", sweepDone, mPhase == 2);
      check(intervalKick == mKick, "R3 intervalKick", intervalKick, mKick);
      check(outEnable == expEnable(),
            mPhase == 0 ? "R10 outEnable" : contMode ? "R7 outEnable" :
            extBurst ? "R9 outEnable" : "R8 outEnable", outEnable, expEnable());
    end
  end

  // stand-in timer: interval every 7 cycles, burst for the first 3
  always @(negedge clk) begin
    tick = (tick + 1) % 7;
    intervalDone = (tick == 6);
    burstActive  = (tick < 3);
  end

  task automatic pulse(input int hi, input int lo);
    @(negedge clk) ctrlPin = 1'b1;
    repeat (hi) @(negedge clk);
    ctrlPin = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!sweepDone && n < 400) begin @(negedge clk); n++; end
    check(sweepDone == 1'b1, tag, sweepDone, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(freqWord == 0 && !outEnable && !sweepDone && !intervalKick,
          "R1 reset outputs", {freqWord, outEnable, sweepDone, intervalKick}, 0);
    rstN = 1'b1;
    modelOn = 1;
    repeat (4) @(negedge clk);
    check(freqWord == 0 && !outEnable, "R1 idle after reset", freqWord, 0);

    // R2: start latency through the synchroniser, continuous auto mode
    startFreq = 24'h001000; deltaWord = 24'h000100; incCount = 3;
    contMode = 1; extBurst = 0; extIncr = 0;
    @(negedge clk) ctrlPin = 1'b1;
    @(posedge clk); @(posedge clk); #3;
    check(freqWord == 0, "R2 not yet loaded", freqWord, 0);
    @(posedge clk); #3;
    check(freqWord == 24'h001000, "R2 loaded on second edge", freqWord, 24'h001000);
    @(negedge clk) ctrlPin = 1'b0;
    waitDone("R4 sweep finished");
    check(freqWord == 24'h001300, "R4 final word", freqWord, 24'h001300);
    repeat (20) @(negedge clk);
    check(freqWord == 24'h001300 && outEnable, "R7 held while done", freqWord, 24'h001300);

    // internal burst gating, pin pulses during the run are ignored (R5)
    contMode = 0; incCount = 4; startFreq = 24'h020000; deltaWord = 24'h000010;
    pulse(3, 10);
    pulse(2, 10);
    pulse(4, 10);
    waitDone("R8 burst sweep finished");
    check(freqWord == 24'h020040, "R5 pin edges ignored in run", freqWord, 24'h020040);

    // external increment with automatic burst (R6)
    extIncr = 1; incCount = 4; startFreq = 24'h000500; deltaWord = 24'h000005;
    check(sweepDone == 1'b1, "R6 still done before start", sweepDone, 1);
    for (int i = 0; i < 5; i++) pulse(2, 9);
    check(!sweepDone && freqWord == 24'h000514, "R6 last step reached", freqWord, 24'h000514);
    pulse(2, 9);
    check(sweepDone == 1'b1, "R6 finish on extra edge", sweepDone, 1);

    // external increment and external burst (R9)
    extBurst = 1; incCount = 2; startFreq = 24'h00ABCD; deltaWord = 24'h000111;
    pulse(6, 4);
    check(sweepDone == 1'b0, "R3 restart clears done", sweepDone, 0);
    pulse(1, 7);
    pulse(5, 3);
    pulse(3, 6);
    check(sweepDone && freqWord == 24'h00ADEF, "R9 ext burst sweep end", freqWord, 24'h00ADEF);

    // zero increments and wrap-around, auto stepping
    extBurst = 0; extIncr = 0; contMode = 1;
    incCount = 0; startFreq = 24'hFFFFF0; deltaWord = 24'h000020;
    pulse(2, 2);
    waitDone("R4 zero-step sweep");
    check(freqWord == 24'hFFFFF0, "R4 zero steps hold start", freqWord, 24'hFFFFF0);
    incCount = 2;
    pulse(2, 2);
    waitDone("R4 wrap sweep");
    check(freqWord == 24'h000030, "R4 modulo wrap", freqWord, 24'h000030);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule